// File: doc/BRIEF.md
# Rotating ALU with Skip Test

This unit is the arithmetic stage of a small 32-bit processor. It combines two register operands under a three-bit function code (add, subtract, bitwise AND, increment, decrement) to form a raw word. It then passes that word through a right-rotation stage that turns it by 0, 1, 8 or 16 places. The rotated word is the unit's result. The unit has no clock and holds no state.

The same raw word, taken before rotation, is tested under a two-bit skip code. The unit raises a single flag that tells the instruction sequencer to suppress the next instruction. The unit keeps no condition flags and produces no carry or overflow. Operand fetch, write-back and program-counter handling are left to neighbouring logic.

The unit has no state machine. Its three stages are selected purely by the three code fields on its inputs.

Top module: `rot_alu`

## Requirements
- R1: Function code 000 gives opa + opb modulo 2^32.
- R2: Function code 001 gives opa - opb modulo 2^32.
- R3: Function code 010 gives the bitwise AND of opa and opb.
- R4: Function code 011 gives opa + 1 modulo 2^32, and opb has no effect on the result.
- R5: Function code 100 gives opa - 1 modulo 2^32, and opb has no effect on the result.
- R6: Function codes 101, 110 and 111 give a raw word of zero.
- R7: The rotate code selects a right rotation of the raw word: 00 none, 01 by 1, 10 by 8, 11 by 16. For example, a raw word of 1 rotated by 1 becomes 0x80000000.
- R8: Skip code 01 raises skip exactly when bit 31 of the raw word is set, that is, when the word is negative in two's complement.
- R9: Skip code 10 raises skip exactly when the raw word is zero.
- R10: Skip codes 00 and 11 never raise skip.
- R11: The skip test uses the raw word before rotation, so the rotate code never changes skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand; the only operand used by increment and decrement |
| opb | input | 32 | Second operand |
| fn_sel | input | 3 | Function code (000 add, 001 sub, 010 and, 011 inc, 100 dec) |
| rot_sel | input | 2 | Rotate-right amount code |
| skip_sel | input | 2 | Skip condition code (00 never, 01 negative, 10 zero, 11 never) |
| result | output | 32 | Rotated function result |
| skip | output | 1 | Suppress-next-instruction flag |

## Verification
The embedded checks assume that every input bit carries a known 0 or 1 whenever the logic settles. They also assume that codes outside the named function set are still legal, driven values. The stimulus drives every port at each step, starting from all zeros, and changes inputs only after a clock edge of the bench. Results are sampled half a period later, so the checks never see partly updated operands. The vectors cover all eight function codes, all four rotate codes and all four skip codes. They include wrap-around operands and results whose sign differs before and after rotation.

// File: rtl/rot_alu_pkg.sv
package rot_alu_pkg;

    localparam int FN_W   = 3;
    localparam int ROT_W  = 2;
    localparam int SKIP_W = 2;

    typedef enum logic [FN_W-1:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_INC = 3'd3,
        FN_DEC = 3'd4
    } fn_e;

    typedef enum logic [ROT_W-1:0] {
        ROT_NONE = 2'd0,
        ROT_ONE  = 2'd1,
        ROT_BYTE = 2'd2,
        ROT_HALF = 2'd3
    } rot_e;

    typedef enum logic [SKIP_W-1:0] {
        SK_NEVER = 2'd0,
        SK_NEG   = 2'd1,
        SK_ZERO  = 2'd2,
        SK_RSVD  = 2'd3
    } skip_e;

endpackage

// File: rtl/rot_alu_fn.sv
module rot_alu_fn
    import rot_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [FN_W-1:0] fn,
    output logic [W-1:0]    raw
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (fn)
            FN_ADD:  raw = a + b;
            FN_SUB:  raw = a - b;
            FN_AND:  raw = a & b;
            FN_INC:  raw = a + ONE;
            FN_DEC:  raw = a - ONE;
            default: raw = '0;
        endcase
    end

    // Cross-checks by inverse operations
    logic [W-1:0] back_sum;
    logic [W-1:0] back_step;
    always_comb begin
        back_sum  = raw + b;
        back_step = raw - a;
        if (fn == FN_SUB) begin
            p_sub_inverse_r2: assert (back_sum == a);
        end
        if (fn == FN_INC) begin
            p_inc_step_r4: assert (back_step == ONE);
        end
        if (fn == FN_DEC) begin
            p_dec_step_r5: assert (back_step == '1);
        end
        if (fn == FN_AND) begin
            p_and_subset_r3: assert ((raw & ~a) == '0 && (raw & ~b) == '0);
        end
    end

endmodule

// File: rtl/rot_alu_ror.sv
module rot_alu_ror
    import rot_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int AMT1 = 1,
    parameter int AMT2 = 8,
    parameter int AMT3 = 16
) (
    input  logic [W-1:0]     din,
    input  logic [ROT_W-1:0] sel,
    output logic [W-1:0]     dout
);

    localparam int NWAY = 1 << ROT_W;

    function automatic int amt_of(int k);
        case (k)
            1:       return AMT1;
            2:       return AMT2;
            3:       return AMT3;
            default: return 0;
        endcase
    endfunction

    logic [W-1:0] way [NWAY];

    for (genvar k = 0; k < NWAY; k++) begin : g_way
        localparam int AMT = amt_of(k);
        if (AMT == 0) begin : g_pass
            assign way[k] = din;
        end else begin : g_turn
            assign way[k] = {din[AMT-1:0], din[W-1:AMT]};
        end
    end

    assign dout = way[sel];

    always_comb begin
        p_rot_keeps_bits_r7: assert ($countones(dout) == $countones(din));
        if (sel == ROT_NONE) begin
            p_rot_none_r7: assert (dout == din);
        end
        if (sel == ROT_ONE) begin
            p_rot_one_lsb_r7: assert (dout[W-1] == din[0]);
        end
    end

endmodule

// File: rtl/rot_alu_skip.sv
module rot_alu_skip
    import rot_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      raw,
    input  logic [SKIP_W-1:0] sel,
    output logic              skip
);

    logic is_neg;
    logic is_zero;

    assign is_neg  = raw[W-1];
    assign is_zero = (raw == '0);

    always_comb begin
        unique case (sel)
            SK_NEG:  skip = is_neg;
            SK_ZERO: skip = is_zero;
            default: skip = 1'b0;
        endcase
    end

    always_comb begin
        if (sel == SK_NEVER || sel == SK_RSVD) begin
            p_skip_never_r10: assert (!skip);
        end
        if (skip && sel == SK_NEG) begin
            p_skip_neg_r8: assert ($signed(raw) < 0);
        end
        if (skip && sel == SK_ZERO) begin
            p_skip_zero_r9: assert ($countones(raw) == 0);
        end
    end

endmodule

// File: rtl/rot_alu.sv
module rot_alu
    import rot_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [FN_W-1:0]   fn_sel,
    input  logic [ROT_W-1:0]  rot_sel,
    input  logic [SKIP_W-1:0] skip_sel,
    output logic [W-1:0]      result,
    output logic              skip
);

    logic [W-1:0] raw;

    rot_alu_fn #(.W(W)) u_fn (
        .a   (opa),
        .b   (opb),
        .fn  (fn_sel),
        .raw (raw)
    );

    rot_alu_ror #(.W(W), .AMT1(1), .AMT2(8), .AMT3(16)) u_ror (
        .din  (raw),
        .sel  (rot_sel),
        .dout (result)
    );

    rot_alu_skip #(.W(W)) u_skip (
        .raw  (raw),
        .sel  (skip_sel),
        .skip (skip)
    );

    always_comb begin
        if (fn_sel > FN_DEC) begin
            p_unused_fn_zero_r6: assert (result == '0);
        end
        if (skip_sel == SK_NEG && rot_sel != ROT_NONE) begin
            p_skip_prerot_r11: assert (skip == raw[W-1]);
        end
    end

endmodule

// File: tb/sim_rot_alu.sv
module sim_rot_alu;

    logic        clk = 1'b0;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [2:0]  fn_sel;
    logic [1:0]  rot_sel;
    logic [1:0]  skip_sel;
    logic [31:0] result;
    logic        skip;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rot_alu u0 (
        .opa      (opa),
        .opb      (opb),
        .fn_sel   (fn_sel),
        .rot_sel  (rot_sel),
        .skip_sel (skip_sel),
        .result   (result),
        .skip     (skip)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  fn;
        logic [1:0]  rot;
        logic [1:0]  sk;
        logic [31:0] exp_r;
        logic        exp_s;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{32'h00000005, 32'h00000007, 3'd0, 2'd0, 2'd0, 32'h0000000C, 1'b0, 4'd1},
        '{32'hFFFFFFFF, 32'h00000002, 3'd0, 2'd0, 2'd2, 32'h00000001, 1'b0, 4'd1},
        '{32'h80000000, 32'h80000000, 3'd0, 2'd0, 2'd2, 32'h00000000, 1'b1, 4'd9},
        '{32'h00000003, 32'h00000005, 3'd1, 2'd0, 2'd1, 32'hFFFFFFFE, 1'b1, 4'd8},
        '{32'h00000009, 32'h00000009, 3'd1, 2'd0, 2'd1, 32'h00000000, 1'b0, 4'd2},
        '{32'hF0F0F0F0, 32'h3C3C3C3C, 3'd2, 2'd0, 2'd0, 32'h30303030, 1'b0, 4'd3},
        '{32'h7FFFFFFF, 32'h12345678, 3'd3, 2'd0, 2'd1, 32'h80000000, 1'b1, 4'd4},
        '{32'h00000000, 32'hFFFFFFFF, 3'd4, 2'd0, 2'd2, 32'hFFFFFFFF, 1'b0, 4'd5},
        '{32'h00000001, 32'h00000005, 3'd4, 2'd0, 2'd2, 32'h00000000, 1'b1, 4'd5},
        '{32'h00001234, 32'h00005678, 3'd5, 2'd0, 2'd2, 32'h00000000, 1'b1, 4'd6},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 3'd7, 2'd0, 2'd0, 32'h00000000, 1'b0, 4'd6},
        '{32'h00000001, 32'h00000001, 3'd2, 2'd1, 2'd1, 32'h80000000, 1'b0, 4'd11},
        '{32'h12345678, 32'h00000000, 3'd0, 2'd2, 2'd0, 32'h78123456, 1'b0, 4'd7},
        '{32'h12345678, 32'h00000000, 3'd0, 2'd3, 2'd0, 32'h56781234, 1'b0, 4'd7},
        '{32'h00000000, 32'h00000001, 3'd1, 2'd1, 2'd3, 32'hFFFFFFFF, 1'b0, 4'd10},
        '{32'h00000000, 32'h00000000, 3'd0, 2'd0, 2'd3, 32'h00000000, 1'b0, 4'd10},
        '{32'h00000000, 32'h00000000, 3'd0, 2'd0, 2'd0, 32'h00000000, 1'b0, 4'd10},
        '{32'h00000080, 32'h00000000, 3'd0, 2'd2, 2'd1, 32'h80000000, 1'b0, 4'd11},
        '{32'h00000000, 32'h00000002, 3'd1, 2'd3, 2'd1, 32'hFFFEFFFF, 1'b1, 4'd7}
    };

    function automatic string tag_of(logic [3:0] k);
        case (k)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] f, input logic [1:0] r,
                         input logic [1:0] s);
        @(posedge clk);
        #1;
        opa = a; opb = b; fn_sel = f; rot_sel = r; skip_sel = s;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] exp_r,
                         input logic exp_s);
        total++;
        if (result !== exp_r || skip !== exp_s) begin
            bad++;
            $display("FAIL %s: result=%h skip=%b expected result=%h skip=%b",
                     tag, result, skip, exp_r, exp_s);
        end
    endtask

    initial begin
        opa = '0; opb = '0; fn_sel = '0; rot_sel = '0; skip_sel = '0;
        @(negedge clk);
        // Initial all-zero inputs: add of zeros, no skip (R1, R10)
        check("R1", 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].fn, VECS[i].rot, VECS[i].sk);
            check(tag_of(VECS[i].req), VECS[i].exp_r, VECS[i].exp_s);
        end

        // R4: opb has no effect on increment
        for (int i = 0; i < 4; i++) begin
            apply(32'hFFFFFFFF, 32'h11111111 * i, 3'd3, 2'd0, 2'd2);
            check("R4", 32'h00000000, 1'b1);
        end
        // R5: opb has no effect on decrement
        for (int i = 0; i < 4; i++) begin
            apply(32'h80000000, ~(32'h01010101 * i), 3'd4, 2'd0, 2'd1);
            check("R5", 32'h7FFFFFFF, 1'b0);
        end
        // R6: function code 110
        apply(32'hDEADBEEF, 32'h01234567, 3'd6, 2'd3, 2'd1);
        check("R6", 32'h00000000, 1'b0);
        // R11: every rotate code leaves skip unchanged for a negative raw word
        apply(32'h00000000, 32'h00000003, 3'd1, 2'd0, 2'd1);
        check("R11", 32'hFFFFFFFD, 1'b1);
        apply(32'h00000000, 32'h00000003, 3'd1, 2'd1, 2'd1);
        check("R11", 32'hFFFFFFFE, 1'b1);
        apply(32'h00000000, 32'h00000003, 3'd1, 2'd2, 2'd1);
        check("R11", 32'hFDFFFFFF, 1'b1);
        apply(32'h00000000, 32'h00000003, 3'd1, 2'd3, 2'd1);
        check("R11", 32'hFFFDFFFF, 1'b1);
        // R7: rotation by 1 with the low bit clear
        apply(32'h00000002, 32'h00000000, 3'd0, 2'd1, 2'd0);
        check("R7", 32'h00000001, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule